// File: doc/BRIEF.md
# Bank-Driven Nametable Select CHR Mapper

This block maps the 14-bit video address of a tile-based video cartridge onto a banked CHR ROM address. It holds six CHR bank registers. A CPU loads them through two write ports: a select port that names the target register and sets the layout, and a data port that writes the named register. Two registers are 2KB windows and four are 1KB windows. A layout bit swaps which half of the pattern space each group covers.

The top bit of each bank value is not a ROM address line. It drives the A10 select of the nametable RAM, so the CHR ROM space is half of what an 8-bit bank value would otherwise reach. Video address bit 13 is not decoded, so nametable fetches at $2000-$2FFF reuse the bank windows at $0000-$0FFF. Software gets an independent nametable page for each 1KB quarter by setting the layout bit and placing the four 1KB banks in the lower half. The select is purely combinational in the present address and register contents.

Top module: `chr_nt_mapper`

## Requirements
- R1: While reset is low and directly after it, all six bank values and the layout bit are zero. In that state every address gives nt_a10_o = 0, and chr_addr_o[16:11] = 0.
- R2: A write with cpu_a0_i = 0 stores the target index from data bits 2:0 and the layout bit from data bit 7. Data bits 6:3 are ignored. A data write while the index is 6 or 7 changes no bank.
- R3: A write with cpu_a0_i = 1 loads the full 8-bit data into the bank register named by the stored index.
- R4: With layout bit 0, the 2KB banks 0 and 1 cover $0000-$07FF and $0800-$0FFF, and the 1KB banks 2..5 cover $1000, $1400, $1800 and $1C00 in that order.
- R5: With layout bit 1, the 1KB banks 2..5 cover $0000, $0400, $0800 and $0C00, and banks 0 and 1 cover $1000-$17FF and $1800-$1FFF.
- R6: For a 2KB bank, chr_addr_o[10] equals video address bit 10 rather than bank bit 0.
- R7: chr_addr_o is {bank[6:0], vid_addr_i[9:0]}, with bit 10 as given by R6. Bank bit 7 never reaches chr_addr_o.
- R8: nt_a10_o equals bit 7 of the bank covering the current address. Video bit 13 is ignored, so $2000-$2FFF take their select from the banks at $0000-$0FFF.
- R9: Outputs are combinational in the present address and registers. The same address gives the same result whatever was accessed before.
- R10: A register write takes effect at the rising clock edge that samples cpu_we_i. Before that edge the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | CPU write strobe, sampled at the rising edge |
| cpu_a0_i | input | 1 | 0 = select port, 1 = data port |
| cpu_wdata_i | input | 8 | CPU write data |
| vid_addr_i | input | 14 | Video bus address |
| chr_addr_o | output | 17 | Banked CHR ROM address |
| nt_a10_o | output | 1 | Nametable RAM A10 select |

## Verification
The checks assume that cpu_we_i stays low while reset is applied. They also assume the video address is not driven from the write path. Two checks depend on this: the hold check (outputs stay fixed when no write happened and the address is steady) and the ignored-index check. The bench keeps within these limits by changing the address and the write strobe only after falling clock edges, and by holding the strobe low around every reset. Nametable selection is covered by checking $2000, $2400, $2800 and $2C00 under both layout settings, with bank values whose bit 7 differs from bank to bank.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
  localparam int unsigned NUM_BANKS = 6;
  localparam int unsigned IDX_W     = 3;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             wide;
  } bank_pick_t;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_map_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned NBANK  = NUM_BANKS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic                          a0_i,
  input  logic [BANK_W-1:0]             wdata_i,
  output logic [IDX_W-1:0]              sel_o,
  output logic                          inv_o,
  output logic [NBANK-1:0][BANK_W-1:0]  banks_o
);
  logic [IDX_W-1:0] sel_q;
  logic             inv_q;
  logic             unused_mid;

  assign unused_mid = ^wdata_i[BANK_W-2:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      inv_q <= 1'b0;
    end else if (we_i && !a0_i) begin
      sel_q <= wdata_i[IDX_W-1:0];
      inv_q <= wdata_i[BANK_W-1];
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        banks_o[g] <= '0;
      else if (we_i && a0_i && (sel_q == IDX_W'(g)))
        banks_o[g] <= wdata_i;
    end
  end

  assign sel_o = sel_q;
  assign inv_o = inv_q;
endmodule

// File: rtl/chr_bank_pick.sv
module chr_bank_pick
  import chr_map_pkg::*;
(
  input  logic [2:0]  win_i,   // video address bits 12:10
  input  logic        inv_i,
  output bank_pick_t  pick_o
);
  logic hi_half;

  always_comb begin
    hi_half = win_i[2] ^ inv_i;
    if (!hi_half) begin
      pick_o.wide = 1'b1;
      pick_o.idx  = {{(IDX_W-1){1'b0}}, win_i[1]};
    end else begin
      pick_o.wide = 1'b0;
      pick_o.idx  = IDX_W'(2) + IDX_W'(win_i[1:0]);
    end
  end
endmodule

// File: rtl/chr_addr_form.sv
module chr_addr_form
  import chr_map_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned NBANK  = NUM_BANKS,
  parameter int unsigned WIN_W  = 10,
  localparam int unsigned ROM_AW = BANK_W - 1 + WIN_W
) (
  input  logic [NBANK-1:0][BANK_W-1:0] banks_i,
  input  bank_pick_t                   pick_i,
  input  logic [WIN_W:0]               low_i,   // video address bits 10:0
  output logic [ROM_AW-1:0]            rom_o,
  output logic                         nt_o
);
  logic [BANK_W-1:0] cur;
  logic              b0;

  always_comb begin
    cur   = banks_i[pick_i.idx];
    b0    = pick_i.wide ? low_i[WIN_W] : cur[0];
    rom_o = {cur[BANK_W-2:1], b0, low_i[WIN_W-1:0]};
    nt_o  = cur[BANK_W-1];
  end
endmodule

// File: rtl/chr_nt_mapper.sv
module chr_nt_mapper
  import chr_map_pkg::*;
#(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned VA_W   = 14,
  parameter int unsigned WIN_W  = 10,
  localparam int unsigned ROM_AW = BANK_W - 1 + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_we_i,
  input  logic              cpu_a0_i,
  input  logic [BANK_W-1:0] cpu_wdata_i,
  input  logic [VA_W-1:0]   vid_addr_i,
  output logic [ROM_AW-1:0] chr_addr_o,
  output logic              nt_a10_o
);
  logic [IDX_W-1:0]                  sel_q;
  logic                              inv_q;
  logic [NUM_BANKS-1:0][BANK_W-1:0]  banks;
  bank_pick_t                        pick;
  logic                              unused_a13;

  assign unused_a13 = vid_addr_i[VA_W-1];

  chr_bank_regs #(.BANK_W(BANK_W), .NBANK(NUM_BANKS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cpu_we_i),
    .a0_i    (cpu_a0_i),
    .wdata_i (cpu_wdata_i),
    .sel_o   (sel_q),
    .inv_o   (inv_q),
    .banks_o (banks)
  );

  chr_bank_pick u_pick (
    .win_i  (vid_addr_i[WIN_W+2:WIN_W]),
    .inv_i  (inv_q),
    .pick_o (pick)
  );

  chr_addr_form #(.BANK_W(BANK_W), .NBANK(NUM_BANKS), .WIN_W(WIN_W)) u_form (
    .banks_i (banks),
    .pick_i  (pick),
    .low_i   (vid_addr_i[WIN_W:0]),
    .rom_o   (chr_addr_o),
    .nt_o    (nt_a10_o)
  );
endmodule

// File: rtl/chr_nt_mapper_chk.sv
module chr_nt_mapper_chk #(
  parameter int unsigned BANK_W = 8,
  parameter int unsigned VA_W   = 14,
  parameter int unsigned WIN_W  = 10,
  parameter int unsigned NBANK  = 6,
  localparam int unsigned ROM_AW = BANK_W - 1 + WIN_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_we_i,
  input logic              cpu_a0_i,
  input logic [VA_W-1:0]   vid_addr_i,
  input logic [ROM_AW-1:0] chr_addr_o,
  input logic              nt_a10_o,
  input logic [2:0]        sel_i,
  input logic              inv_i
);
  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!nt_a10_o && chr_addr_o[ROM_AW-1:WIN_W+1] == '0));

  a_r7_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_addr_o[WIN_W-1:0] == vid_addr_i[WIN_W-1:0]);

  a_r6_wide_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vid_addr_i[WIN_W+2] == inv_i) |-> (chr_addr_o[WIN_W] == vid_addr_i[WIN_W]));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cpu_we_i) && $stable(vid_addr_i)) |-> ($stable(chr_addr_o) && $stable(nt_a10_o)));

  a_r2_bad_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cpu_we_i && cpu_a0_i && (sel_i >= 3'(NBANK))) && $stable(vid_addr_i))
      |-> ($stable(chr_addr_o) && $stable(nt_a10_o)));
endmodule

bind chr_nt_mapper chr_nt_mapper_chk #(
  .BANK_W(BANK_W), .VA_W(VA_W), .WIN_W(WIN_W), .NBANK(6)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_we_i   (cpu_we_i),
  .cpu_a0_i   (cpu_a0_i),
  .vid_addr_i (vid_addr_i),
  .chr_addr_o (chr_addr_o),
  .nt_a10_o   (nt_a10_o),
  .sel_i      (sel_q),
  .inv_i      (inv_q)
);

// File: tb/chr_nt_mapper_test.sv
`timescale 1ns/1ps
module chr_nt_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        a0 = 1'b0;
  logic [7:0]  wdata = '0;
  logic [13:0] vid = '0;
  logic [16:0] rom;
  logic        nt;
  int          n_run = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  chr_nt_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_a0_i(a0),
    .cpu_wdata_i(wdata), .vid_addr_i(vid), .chr_addr_o(rom), .nt_a10_o(nt)
  );

  localparam logic [7:0] BANK_INIT [6] = '{8'h85, 8'h12, 8'hA1, 8'h04, 8'h83, 8'h46};

  // {inv, addr, nt, rom} ; R4/R5/R6/R7/R8/R9
  localparam int NV = 19;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 14'h2000, 1'b1, 17'h01000},
    {1'b0, 14'h2400, 1'b1, 17'h01400},
    {1'b0, 14'h2800, 1'b0, 17'h04800},
    {1'b0, 14'h2C00, 1'b0, 17'h04C00},
    {1'b0, 14'h1000, 1'b1, 17'h08400},
    {1'b0, 14'h17FF, 1'b0, 17'h013FF},
    {1'b0, 14'h1800, 1'b1, 17'h00C00},
    {1'b0, 14'h1C05, 1'b0, 17'h11805},
    {1'b0, 14'h3C05, 1'b0, 17'h11805},
    {1'b1, 14'h2000, 1'b1, 17'h08400},
    {1'b1, 14'h2400, 1'b0, 17'h01000},
    {1'b1, 14'h2800, 1'b1, 17'h00C00},
    {1'b1, 14'h2C00, 1'b0, 17'h11800},
    {1'b1, 14'h1000, 1'b1, 17'h01000},
    {1'b1, 14'h1400, 1'b1, 17'h01400},
    {1'b1, 14'h1BFF, 1'b0, 17'h04BFF},
    {1'b1, 14'h1C00, 1'b0, 17'h04C00},
    {1'b1, 14'h0123, 1'b1, 17'h08523},
    {1'b0, 14'h2400, 1'b1, 17'h01400}
  };

  task automatic cpu_wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; a0 = port; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [13:0] a,
                     input logic e_nt, input logic [16:0] e_rom);
    vid = a;
    #1;
    n_run++;
    if (nt !== e_nt || rom !== e_rom) begin
      n_fail++;
      $display("FAIL %s addr=%h nt=%b exp=%b rom=%h exp=%h", tag, a, nt, e_nt, rom, e_rom);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < 6; i++) begin
      cpu_wr(1'b0, 8'(i));
      cpu_wr(1'b1, BANK_INIT[i]);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 during and after reset
    chk("R1 in reset $2C00", 14'h2C00, 1'b0, 17'h00400);
    #7 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset $3FFF", 14'h3FFF, 1'b0, 17'h003FF);
    chk("R1 after reset $2000", 14'h2000, 1'b0, 17'h00000);

    // R3 load all banks
    load_all();

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      cpu_wr(1'b0, {v[32], 7'h00});
      chk("R8 vector", v[31:18], v[17], v[16:0]);
    end

    // R2 indices 6 and 7 change nothing
    cpu_wr(1'b0, 8'h06); cpu_wr(1'b1, 8'hFF);
    cpu_wr(1'b0, 8'h07); cpu_wr(1'b1, 8'hFF);
    chk("R2 idx6/7 $2000", 14'h2000, 1'b1, 17'h01000);
    chk("R2 idx6/7 $1C05", 14'h1C05, 1'b0, 17'h11805);

    // R2 bits 6:3 ignored: 0x7A -> index 2, layout 0
    cpu_wr(1'b0, 8'h7A); cpu_wr(1'b1, 8'h22);
    chk("R2/R3 mid bits ignored $1000", 14'h1000, 1'b0, 17'h08800);

    // R10 timing of a data write to bank 0
    cpu_wr(1'b0, 8'h00);
    vid = 14'h2000;
    @(negedge clk);
    we = 1'b1; a0 = 1'b1; wdata = 8'h05;
    chk("R10 before edge", 14'h2000, 1'b1, 17'h01000);
    @(posedge clk);
    #1 we = 1'b0;
    chk("R10 after edge", 14'h2000, 1'b0, 17'h01000);
    chk("R6 wide a10 $2400", 14'h2400, 1'b0, 17'h01400);

    // R9 history independence
    chk("R9 revisit $2800", 14'h2800, 1'b0, 17'h04800);
    chk("R9 revisit $2000", 14'h2000, 1'b0, 17'h01000);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    chk("R1 async reset $1000", 14'h1000, 1'b0, 17'h00000);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 post reset $2800", 14'h2800, 1'b0, 17'h00000);
    chk("R1 post reset layout $0C00", 14'h0C00, 1'b0, 17'h00400);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule